// File: doc/BRIEF.md
# Variable-Tap Serial Delay Line

A one-bit delay line whose length can be changed while it runs. Serial data enters a chain of shift sections, each sixteen one-bit stages deep. A tap address selects the stage that drives the data output. Address value `n` gives a delay of `n + 1` enabled clock edges. A typical use is to balance two pipeline paths whose latencies differ, without rebuilding either path.

Several sections can be chained by parameter. The upper bits of the tap address then pick a section and the lower four bits pick a stage inside it. An optional output register adds one more enabled cycle of delay. The last stage of the chain is always brought out, so further delay lines can be cascaded after this one. Stages shift only on clock edges where the enable is high. There is no reset of the stored bits: their power-up contents come from a parameter.

There is no state machine in this block. Its behaviour is set by the shift chain, the tap decode and the optional capture register.

Top module: `dly_tap_line`

## Requirements
- R1: On a rising clock edge with `ce` high, stage 0 takes `din` and every stage `i > 0` takes the old value of stage `i - 1`. Global stage numbering runs from 0 (newest) to SECTIONS*DEPTH-1 (oldest).
- R2: With no output register (OUT_REG = 0), `dout` equals the bit that entered `tap_addr + 1` enabled edges earlier, that is, the current content of global stage `tap_addr`.
- R3: On an edge with `ce` low, all stored stages, the output register and `cascade_out` keep their values whatever `din` does.
- R4: The tap select is combinational. A change of `tap_addr` changes `dout` (OUT_REG = 0) in the same cycle and does not alter any stored stage.
- R5: `cascade_out` always shows the oldest stage (global stage SECTIONS*DEPTH-1), independent of `tap_addr`.
- R6: Bits pass from the last stage of section `k` into stage 0 of section `k + 1`. Tap address bits [3:0] select the stage and the bits above select the section, so address 16 is the first stage of the second section.
- R7: With OUT_REG = 1, `dout` is a register that loads the tapped bit on each enabled edge. This gives a total delay of `tap_addr + 2` enabled edges. The register holds 0 at power-up.
- R8: At power-up, global stage `i` holds bit `i` of parameter INIT_BITS. INIT_BITS defaults to all zeros.
- R9: A tap address above SECTIONS*DEPTH-1, which is possible when the section count is not a power of two, selects the oldest stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| ce | input | 1 | Shift enable; also enables the output register |
| din | input | 1 | Serial data in |
| tap_addr | input | ADDR_W = clog2(SECTIONS*DEPTH) | Stage selected for `dout` |
| dout | output | 1 | Tapped bit, registered when OUT_REG = 1 |
| cascade_out | output | 1 | Oldest stage of the chain, for cascading |

## Verification
A change of tap address and a shift can fall in the same cycle. `dout` must then show the newly selected stage of the pre-edge contents before the edge, and that stage's shifted contents after it. The bench provokes this by driving a fresh random `tap_addr`, `din` and `ce` on every negative clock edge, so that retargeting coincides with both enabled and held edges. It judges each cycle against a bench model of the stage history, and an unchanged re-sweep after address-only cycles shows that retargeting did not disturb the data.

// File: rtl/dly_pkg.sv
package dly_pkg;

    // Stages in one section; the tap decode relies on this being a power of two.
    localparam int SECTION_DEPTH = 16;

    // Width of an index that must hold at least one value.
    function automatic int idx_width(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/dly_section.sv
module dly_section #(
    parameter int                 DEPTH     = 16,
    parameter logic [DEPTH-1:0]   INIT_BITS = '0,
    localparam int                STG_W     = dly_pkg::idx_width(DEPTH)
) (
    input  logic             clk,
    input  logic             ce,
    input  logic             sin,
    input  logic [STG_W-1:0] tap,
    output logic             tap_bit,
    output logic             sout
);

    // stage[0] holds the newest bit, stage[DEPTH-1] the oldest
    logic [DEPTH-1:0] stage = INIT_BITS;

    always_ff @(posedge clk) begin
        if (ce) begin
            stage <= {stage[DEPTH-2:0], sin};
        end
    end

    always_comb begin
        tap_bit = stage[tap];
    end

    assign sout = stage[DEPTH-1];

    // Flag that at least one edge has passed, so $past has history.
    logic past_ok = 1'b0;
    always_ff @(posedge clk) begin
        past_ok <= 1'b1;
    end

    // R1
    shift_in_chk: assert property (@(posedge clk) disable iff (!past_ok)
        $past(ce) |-> stage[0] == $past(sin));

    // R1
    shift_chain_chk: assert property (@(posedge clk) disable iff (!past_ok)
        $past(ce) |-> stage[DEPTH-1:1] == $past(stage[DEPTH-2:0]));

    // R3
    stage_hold_chk: assert property (@(posedge clk) disable iff (!past_ok)
        !$past(ce) |-> $stable(stage));

endmodule

// File: rtl/dly_tap_decode.sv
module dly_tap_decode #(
    parameter int  SECTIONS = 2,
    parameter int  DEPTH    = 16,
    localparam int TOTAL    = SECTIONS * DEPTH,
    localparam int ADDR_W   = dly_pkg::idx_width(TOTAL),
    localparam int STG_W    = dly_pkg::idx_width(DEPTH),
    localparam int SEC_W    = dly_pkg::idx_width(SECTIONS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SEC_W-1:0]  sec_idx,
    output logic [STG_W-1:0]  stg_idx
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(TOTAL - 1);

    logic [ADDR_W-1:0] eff_addr;

    // Saturate addresses that point beyond the chain onto its oldest stage.
    always_comb begin
        eff_addr = (addr > LAST_ADDR) ? LAST_ADDR : addr;
    end

    assign stg_idx = eff_addr[STG_W-1:0];

    generate
        if (SECTIONS > 1) begin : g_multi
            logic [ADDR_W-STG_W-1:0] upper;
            assign upper   = eff_addr[ADDR_W-1:STG_W];
            assign sec_idx = SEC_W'(upper);
        end else begin : g_single
            assign sec_idx = '0;
        end
    endgenerate

endmodule

// File: rtl/dly_out_stage.sv
module dly_out_stage #(
    parameter bit USE_REG = 1'b0
) (
    input  logic clk,
    input  logic ce,
    input  logic d,
    output logic q
);

    logic cap = 1'b0;

    always_ff @(posedge clk) begin
        if (ce) begin
            cap <= d;
        end
    end

    generate
        if (USE_REG) begin : g_reg
            assign q = cap;
        end else begin : g_pass
            assign q = d;
        end
    endgenerate

    logic past_ok = 1'b0;
    always_ff @(posedge clk) begin
        past_ok <= 1'b1;
    end

    // R7
    out_capture_chk: assert property (@(posedge clk) disable iff (!past_ok)
        $past(ce) |-> cap == $past(d));

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!past_ok)
        !$past(ce) |-> $stable(cap));

endmodule

// File: rtl/dly_tap_line.sv
module dly_tap_line #(
    parameter int  SECTIONS = 2,
    parameter bit  OUT_REG  = 1'b0,
    parameter logic [SECTIONS*dly_pkg::SECTION_DEPTH-1:0] INIT_BITS = '0,
    localparam int DEPTH    = dly_pkg::SECTION_DEPTH,
    localparam int TOTAL    = SECTIONS * DEPTH,
    localparam int ADDR_W   = dly_pkg::idx_width(TOTAL)
) (
    input  logic              clk,
    input  logic              ce,
    input  logic              din,
    input  logic [ADDR_W-1:0] tap_addr,
    output logic              dout,
    output logic              cascade_out
);

    localparam int STG_W = dly_pkg::idx_width(DEPTH);
    localparam int SEC_W = dly_pkg::idx_width(SECTIONS);

    logic [STG_W-1:0]    stg_idx;
    logic [SEC_W-1:0]    sec_idx;
    logic [SECTIONS-1:0] sec_tap;
    logic [SECTIONS-1:0] sec_last;
    logic [SECTIONS-1:0] sec_in;
    logic                tapped;

    dly_tap_decode #(
        .SECTIONS (SECTIONS),
        .DEPTH    (DEPTH)
    ) u_decode (
        .addr    (tap_addr),
        .sec_idx (sec_idx),
        .stg_idx (stg_idx)
    );

    generate
        for (genvar k = 0; k < SECTIONS; k++) begin : g_sec
            if (k == 0) begin : g_head
                assign sec_in[k] = din;
            end else begin : g_link
                assign sec_in[k] = sec_last[k-1];
            end

            dly_section #(
                .DEPTH     (DEPTH),
                .INIT_BITS (INIT_BITS[k*DEPTH +: DEPTH])
            ) u_section (
                .clk     (clk),
                .ce      (ce),
                .sin     (sec_in[k]),
                .tap     (stg_idx),
                .tap_bit (sec_tap[k]),
                .sout    (sec_last[k])
            );
        end
    endgenerate

    always_comb begin
        tapped = sec_tap[sec_idx];
    end

    dly_out_stage #(
        .USE_REG (OUT_REG)
    ) u_out (
        .clk (clk),
        .ce  (ce),
        .d   (tapped),
        .q   (dout)
    );

    assign cascade_out = sec_last[SECTIONS-1];

    logic past_ok = 1'b0;
    always_ff @(posedge clk) begin
        past_ok <= 1'b1;
    end

    // R3
    cascade_hold_chk: assert property (@(posedge clk) disable iff (!past_ok)
        !$past(ce) |-> $stable(cascade_out));

    generate
        if (SECTIONS > 1) begin : g_link_chk
            // R6
            section_link_chk: assert property (@(posedge clk) disable iff (!past_ok)
                $past(ce) |-> cascade_out == $past(u_decode.addr == u_decode.addr ?
                    g_sec[SECTIONS-1].u_section.stage[DEPTH-2] : 1'b0));
        end
    endgenerate

endmodule

// File: tb/dly_tap_line_bench.sv
`timescale 1ns/1ps
module dly_tap_line_bench;

    localparam int          N1    = 32;
    localparam int          N2    = 48;
    localparam logic [31:0] INIT1 = 32'hC35A_96F1;

    logic       clk = 1'b0;
    logic       ce  = 1'b0;
    logic       din = 1'b0;
    logic [4:0] a1  = '0;
    logic [5:0] a2  = '0;
    logic       dout1, casc1, dout2, casc2;

    always #10 clk = ~clk;

    dly_tap_line #(
        .SECTIONS  (2),
        .OUT_REG   (1'b0),
        .INIT_BITS (INIT1)
    ) u_dly_tap_line (
        .clk (clk), .ce (ce), .din (din), .tap_addr (a1),
        .dout (dout1), .cascade_out (casc1)
    );

    dly_tap_line #(
        .SECTIONS (3),
        .OUT_REG  (1'b1)
    ) u_dly_tap_line_reg (
        .clk (clk), .ce (ce), .din (din), .tap_addr (a2),
        .dout (dout2), .cascade_out (casc2)
    );

    int   vectors = 0;
    int   fails   = 0;
    bit   done    = 1'b0;
    logic h1 [N1];
    logic h2 [N2];
    logic r2 = 1'b0;

    task automatic chk(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, check before the rising edge,
    // then advance the model by the edge.
    task automatic step(input logic d, input logic e, input logic [4:0] x1,
                        input logic [5:0] x2, input string t1, input string t2);
        int eff2;
        @(negedge clk);
        din = d; ce = e; a1 = x1; a2 = x2;
        #1;
        chk(t1, dout1, h1[x1]);
        chk("R5", casc1, h1[N1-1]);
        chk(t2, dout2, r2);
        chk("R5", casc2, h2[N2-1]);
        @(posedge clk);
        eff2 = (int'(x2) > N2 - 1) ? N2 - 1 : int'(x2);
        if (e) begin
            r2 = h2[eff2];
            for (int i = N1 - 1; i > 0; i--) h1[i] = h1[i-1];
            h1[0] = d;
            for (int i = N2 - 1; i > 0; i--) h2[i] = h2[i-1];
            h2[0] = d;
        end
    endtask

    initial begin
        for (int i = 0; i < N1; i++) h1[i] = INIT1[i];
        for (int i = 0; i < N2; i++) h2[i] = 1'b0;
        void'($urandom(32'd4417));

        // R8: power-up contents, swept with the enable low
        for (int i = 0; i < 48; i++) step(1'b1, 1'b0, 5'(i), 6'(i), "R8", "R8");

        // R1: one enabled edge puts din into stage 0
        step(1'b0, 1'b1, 5'd0, 6'd0, "R1", "R7");
        step(1'b1, 1'b1, 5'd0, 6'd0, "R1", "R7");
        step(1'b0, 1'b0, 5'd0, 6'd0, "R1", "R7");
        step(1'b0, 1'b0, 5'd1, 6'd1, "R1", "R7");

        // R3: din toggles with the enable low; nothing may move
        for (int i = 0; i < 12; i++) step(1'($urandom), 1'b0, 5'd31, 6'd47, "R3", "R3");

        // R4: address-only changes, then a re-sweep of every stage
        for (int i = 0; i < 40; i++) step(1'b0, 1'b0, 5'($urandom), 6'($urandom % 48), "R4", "R4");
        for (int i = 0; i < 32; i++) step(1'b1, 1'b0, 5'(i), 6'(i), "R4", "R4");

        // R6: fill with a pattern, then look across the section boundary
        for (int i = 0; i < 48; i++) step(1'((i * 7) % 5 == 0), 1'b1, 5'd16, 6'd16, "R6", "R6");
        step(1'b0, 1'b0, 5'd15, 6'd15, "R6", "R6");
        step(1'b0, 1'b0, 5'd16, 6'd16, "R6", "R6");
        step(1'b0, 1'b1, 5'd31, 6'd32, "R6", "R6");
        step(1'b1, 1'b1, 5'd16, 6'd31, "R6", "R6");

        // R9: out-of-range addresses on the three-section line
        for (int i = 48; i < 64; i++) step(1'($urandom), 1'b1, 5'(i), 6'(i), "R2", "R9");
        step(1'b0, 1'b0, 5'd0, 6'd63, "R2", "R9");

        // R2 / R7: random stimulus, retargeting and shifting in one cycle
        for (int i = 0; i < 3000; i++)
            step(1'($urandom), ($urandom % 4) != 0, 5'($urandom), 6'($urandom), "R2", "R7");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule